// File: doc/BRIEF.md
# Lowest-Priority Interrupt Destination Router

This block decides which single CPU receives each incoming interrupt request. It keeps one routing entry per interrupt line and one priority-hint register per CPU. A routing entry holds a CPU mask and a mode flag. In fixed mode the request always goes to the CPU named by the lowest set bit of the mask. In redirectable mode the request goes to the CPU with the smallest hint value. The search begins at that same default CPU and moves upward, wrapping past the top, so the default CPU or the first CPU reached after it wins any tie.

Software loads entries and hints through one write port. A hint write picks its CPU from the low address bits. A request presents an interrupt number with a valid bit. One clock later the block drives a registered one-hot CPU vector, the echoed interrupt number and a valid strobe. An entry whose mask is zero is masked and produces no strobe. The build parameter `REDIR_AVAIL` selects the platform variant. When set, every entry resets to redirectable with CPU 0 as its target. When clear, redirection is absent: entries reset to fixed targets spread round-robin over the CPUs, and the mode flag is ignored.

Top module: `irq_dest_router`

## Requirements
- R1: Every delivery strobe carries a CPU vector with exactly one bit set.
- R2: When the mask has several bits set, the default CPU is the lowest-numbered set bit.
- R3: In fixed mode (mode flag 0) the delivered CPU is the default CPU, whatever the hint values.
- R4: In redirectable mode (mode flag 1) the delivered CPU has the smallest hint value. The search starts at the default CPU and runs upward with wrap-around, and a strictly smaller value is needed to move away from the CPU found first.
- R5: Hint levels are encoded 2'b00 idle, 2'b01 busy and 2'b10 going offline. A write of 2'b11 is stored as 2'b10.
- R6: In redirectable mode a CPU whose hint is 2'b10 is never chosen while any CPU has a lower hint. If all CPUs are at 2'b10, the default CPU is chosen.
- R7: With `REDIR_AVAIL`=1, every entry after reset is redirectable with mask 8'h01, so it targets CPU 0.
- R8: With `REDIR_AVAIL`=0, entry i resets to a fixed target of CPU (i mod N_CPU). Written mode flags have no effect, and routing is always fixed.
- R9: A request for an entry whose mask is zero produces no delivery strobe.
- R10: The outputs are registered. `dlv_valid`, `dlv_cpu` and `dlv_irq` reflect the request from exactly one clock earlier, and `dlv_valid` is low in the cycle after a clock with no request.
- R11: A configuration write in the same clock as a request does not affect the routing of that request. That request uses the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_hint_sel | input | 1 | 1: write the hint of CPU cfg_addr; 0: write routing entry cfg_addr |
| cfg_addr | input | IRQ_W (6) | Entry number, or CPU number in its low bits |
| cfg_mask | input | N_CPU (8) | Destination mask for an entry write |
| cfg_redir | input | 1 | Mode flag for an entry write (1 redirectable) |
| cfg_hint | input | 2 | Hint level for a hint write |
| req_valid | input | 1 | Interrupt request strobe |
| req_irq | input | IRQ_W (6) | Interrupt number of the request |
| dlv_valid | output | 1 | Delivery strobe |
| dlv_cpu | output | N_CPU (8) | One-hot destination CPU |
| dlv_irq | output | IRQ_W (6) | Interrupt number being delivered |

## Verification
Each result is due one clock after its request. The request is sampled at a rising edge, and the single output register on the path updates at that edge. The bench drives inputs just after a falling edge and reads the outputs at the next falling edge, half a period after the register has updated. Every drive step is then checked against an expectation that the bench took from its own model before it applied any write in that same step. This makes the write-during-request case and back-to-back requests line up without any extra bookkeeping.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   typedef enum logic [1:0] {
      HINT_IDLE = 2'b00,
      HINT_BUSY = 2'b01,
      HINT_OFF  = 2'b10
   } hint_lvl_e;

   // Out-of-range code saturates to the highest level
   function automatic logic [1:0] hint_clamp(input logic [1:0] raw);
      return (raw == 2'b11) ? HINT_OFF : raw;
   endfunction

endpackage

// File: rtl/irq_route_table.sv
module irq_route_table #(
   parameter int N_IRQ       = 64,
   parameter int N_CPU       = 8,
   parameter bit REDIR_AVAIL = 1'b1,
   localparam int IRQ_W      = $clog2(N_IRQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IRQ_W-1:0] wr_addr,
   input  logic [N_CPU-1:0] wr_mask,
   input  logic             wr_redir,
   input  logic [IRQ_W-1:0] rd_addr,
   output logic [N_CPU-1:0] rd_mask,
   output logic             rd_redir
);

   logic [N_CPU-1:0] mask_q [N_IRQ];
   logic             wr_ok;

   assign wr_ok = wr_en && (int'(wr_addr) < N_IRQ);

   // Reset target: CPU 0 when redirection exists, round-robin spread otherwise
   function automatic logic [N_CPU-1:0] reset_mask(input int idx);
      logic [N_CPU-1:0] m;
      m = '0;
      if (REDIR_AVAIL) m[0] = 1'b1;
      else             m[idx % N_CPU] = 1'b1;
      return m;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_IRQ; i++) mask_q[i] <= reset_mask(i);
      end else if (wr_ok) begin
         mask_q[wr_addr] <= wr_mask;
      end
   end

   assign rd_mask = mask_q[rd_addr];

   generate
      if (REDIR_AVAIL) begin : g_mode_store
         logic mode_q [N_IRQ];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N_IRQ; i++) mode_q[i] <= 1'b1;
            end else if (wr_ok) begin
               mode_q[wr_addr] <= wr_redir;
            end
         end
         assign rd_redir = mode_q[rd_addr];
      end else begin : g_mode_fixed
         logic unused_wr_redir;
         assign unused_wr_redir = wr_redir;
         assign rd_redir        = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/irq_hint_bank.sv
module irq_hint_bank
   import irq_route_pkg::*;
#(
   parameter int N_CPU  = 8,
   parameter int ADDR_W = 6,
   localparam int HW    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [HW-1:0]     wr_lvl,
   output logic [N_CPU*HW-1:0] lvl_flat
);

   logic [HW-1:0] lvl_q [N_CPU];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < N_CPU; c++) lvl_q[c] <= HINT_IDLE;
      end else if (wr_en && (int'(wr_addr) < N_CPU)) begin
         lvl_q[wr_addr] <= hint_clamp(wr_lvl);
      end
   end

   generate
      for (genvar c = 0; c < N_CPU; c++) begin : g_flat
         assign lvl_flat[c*HW +: HW] = lvl_q[c];
      end
   endgenerate

endmodule

// File: rtl/irq_dest_select.sv
module irq_dest_select #(
   parameter int N_CPU = 8,
   localparam int HW    = 2,
   localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
   input  logic [N_CPU-1:0]    mask,
   input  logic                redir,
   input  logic [N_CPU*HW-1:0] lvl_flat,
   output logic                hit,
   output logic [N_CPU-1:0]    target
);

   logic [HW-1:0]    lvl [N_CPU];
   logic [CPU_W-1:0] home_idx;
   logic [CPU_W-1:0] best_idx;
   logic [HW-1:0]    best_lvl;
   logic [CPU_W-1:0] pick_idx;

   generate
      for (genvar c = 0; c < N_CPU; c++) begin : g_unpack
         assign lvl[c] = lvl_flat[c*HW +: HW];
      end
   endgenerate

   // Home CPU: lowest set mask bit
   always_comb begin
      home_idx = '0;
      for (int i = N_CPU - 1; i >= 0; i--) begin
         if (mask[i]) home_idx = CPU_W'(i);
      end
   end

   // Rotating minimum search beginning at the home CPU
   always_comb begin
      int cand;
      best_idx = home_idx;
      best_lvl = lvl[home_idx];
      for (int k = 1; k < N_CPU; k++) begin
         cand = int'(home_idx) + k;
         if (cand >= N_CPU) cand = cand - N_CPU;
         if (lvl[cand] < best_lvl) begin
            best_idx = CPU_W'(cand);
            best_lvl = lvl[cand];
         end
      end
   end

   assign pick_idx = redir ? best_idx : home_idx;
   assign hit      = |mask;

   always_comb begin
      target           = '0;
      target[pick_idx] = 1'b1;
   end

endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router #(
   parameter int N_CPU       = 8,
   parameter int N_IRQ       = 64,
   parameter bit REDIR_AVAIL = 1'b1,
   localparam int IRQ_W      = $clog2(N_IRQ),
   localparam int HW         = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_hint_sel,
   input  logic [IRQ_W-1:0] cfg_addr,
   input  logic [N_CPU-1:0] cfg_mask,
   input  logic             cfg_redir,
   input  logic [1:0]       cfg_hint,
   input  logic             req_valid,
   input  logic [IRQ_W-1:0] req_irq,
   output logic             dlv_valid,
   output logic [N_CPU-1:0] dlv_cpu,
   output logic [IRQ_W-1:0] dlv_irq
);

   generate
      if (N_CPU < 2) begin : g_bad_cpu
         $error("irq_dest_router: N_CPU must be at least 2");
      end
      if (N_IRQ < N_CPU) begin : g_bad_irq
         $error("irq_dest_router: N_IRQ must not be below N_CPU");
      end
   endgenerate

   logic [N_CPU-1:0]    ent_mask;
   logic                ent_redir;
   logic [N_CPU*HW-1:0] hint_flat;
   logic                sel_hit;
   logic [N_CPU-1:0]    sel_target;

   irq_route_table #(
      .N_IRQ      (N_IRQ),
      .N_CPU      (N_CPU),
      .REDIR_AVAIL(REDIR_AVAIL)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && !cfg_hint_sel),
      .wr_addr (cfg_addr),
      .wr_mask (cfg_mask),
      .wr_redir(cfg_redir),
      .rd_addr (req_irq),
      .rd_mask (ent_mask),
      .rd_redir(ent_redir)
   );

   irq_hint_bank #(
      .N_CPU (N_CPU),
      .ADDR_W(IRQ_W)
   ) u_hints (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && cfg_hint_sel),
      .wr_addr (cfg_addr),
      .wr_lvl  (cfg_hint),
      .lvl_flat(hint_flat)
   );

   irq_dest_select #(
      .N_CPU(N_CPU)
   ) u_select (
      .mask    (ent_mask),
      .redir   (ent_redir),
      .lvl_flat(hint_flat),
      .hit     (sel_hit),
      .target  (sel_target)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dlv_valid <= 1'b0;
         dlv_cpu   <= '0;
         dlv_irq   <= '0;
      end else begin
         dlv_valid <= req_valid && sel_hit;
         if (req_valid) begin
            dlv_cpu <= sel_target;
            dlv_irq <= req_irq;
         end
      end
   end

endmodule

// File: rtl/irq_dest_router_chk.sv
module irq_dest_router_chk #(
   parameter int N_CPU = 8,
   parameter int IRQ_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [IRQ_W-1:0]   req_irq,
   input logic               dlv_valid,
   input logic [N_CPU-1:0]   dlv_cpu,
   input logic [IRQ_W-1:0]   dlv_irq,
   input logic [N_CPU-1:0]   ent_mask,
   input logic               ent_redir,
   input logic [N_CPU*2-1:0] hint_flat
);

   logic [N_CPU-1:0] off_vec;
   logic [N_CPU-1:0] low_bit;

   always_comb begin
      for (int c = 0; c < N_CPU; c++) off_vec[c] = hint_flat[c*2 +: 2] == 2'b10;
   end
   assign low_bit = ent_mask & (~ent_mask + 1'b1);

   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> $countones(dlv_cpu) == 1);

   p_fixed_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !ent_redir && (ent_mask != '0) |=> dlv_cpu == $past(low_bit));

   p_skip_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid && $past(ent_redir) |->
         ((dlv_cpu & $past(off_vec)) == '0) || ($past(off_vec) == '1));

   p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (ent_mask == '0) |=> !dlv_valid);

   p_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dlv_valid);

   p_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dlv_irq == $past(req_irq));

endmodule

bind irq_dest_router irq_dest_router_chk #(
   .N_CPU(N_CPU),
   .IRQ_W(IRQ_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_irq  (req_irq),
   .dlv_valid(dlv_valid),
   .dlv_cpu  (dlv_cpu),
   .dlv_irq  (dlv_irq),
   .ent_mask (ent_mask),
   .ent_redir(ent_redir),
   .hint_flat(hint_flat)
);

// File: tb/irq_dest_router_tb.sv
`timescale 1ns/1ps
module irq_dest_router_tb;

   localparam int NC = 8;
   localparam int NI = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0, cfg_hint_sel = 1'b0, cfg_redir = 1'b0;
   logic [5:0] cfg_addr = '0;
   logic [7:0] cfg_mask = '0;
   logic [1:0] cfg_hint = '0;
   logic       req_valid = 1'b0;
   logic [5:0] req_irq = '0;
   logic       dlv_valid, rr_valid;
   logic [7:0] dlv_cpu, rr_cpu;
   logic [5:0] dlv_irq, rr_irq;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   logic [7:0] m_mask [NI];
   bit         m_redir [NI];
   logic [1:0] m_hint [NC];

   logic       e_valid;
   logic [7:0] e_cpu;
   logic [5:0] e_irq;
   bit         e_req;
   string      e_tag;

   always #10 clk = ~clk;

   irq_dest_router #(.N_CPU(NC), .N_IRQ(NI), .REDIR_AVAIL(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hint_sel(cfg_hint_sel),
      .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_redir(cfg_redir),
      .cfg_hint(cfg_hint), .req_valid(req_valid), .req_irq(req_irq),
      .dlv_valid(dlv_valid), .dlv_cpu(dlv_cpu), .dlv_irq(dlv_irq));

   irq_dest_router #(.N_CPU(NC), .N_IRQ(NI), .REDIR_AVAIL(1'b0)) u_dut_rr (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hint_sel(cfg_hint_sel),
      .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_redir(cfg_redir),
      .cfg_hint(cfg_hint), .req_valid(req_valid), .req_irq(req_irq),
      .dlv_valid(rr_valid), .dlv_cpu(rr_cpu), .dlv_irq(rr_irq));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Expected destination from the requirements
   function automatic logic [7:0] exp_dest(input int irq);
      int home, best, c;
      logic [7:0] r;
      home = 0;
      for (int i = NC - 1; i >= 0; i--) if (m_mask[irq][i]) home = i;
      best = home;
      if (m_redir[irq]) begin
         for (int k = 1; k < NC; k++) begin
            c = (home + k) % NC;
            if (m_hint[c] < m_hint[best]) best = c;
         end
      end
      r = '0;
      r[best] = 1'b1;
      return r;
   endfunction

   // One clock: drive just after a falling edge, check at the next one
   task automatic step(input bit we, input bit hsel, input int addr, input logic [7:0] mask,
                       input bit redir, input logic [1:0] hint,
                       input bit rq, input int irq, input string tag);
      cfg_we = we; cfg_hint_sel = hsel; cfg_addr = 6'(addr); cfg_mask = mask;
      cfg_redir = redir; cfg_hint = hint; req_valid = rq; req_irq = 6'(irq);
      e_req   = rq;
      e_valid = rq && (m_mask[irq] != '0);
      e_cpu   = exp_dest(irq);
      e_irq   = 6'(irq);
      e_tag   = tag;
      if (we) begin
         if (hsel) begin
            if (addr < NC) m_hint[addr] = (hint == 2'b11) ? 2'b10 : hint;
         end else begin
            m_mask[addr]  = mask;
            m_redir[addr] = redir;
         end
      end
      @(negedge clk);
      check(dlv_valid == e_valid, e_tag, int'(dlv_valid), int'(e_valid));
      if (e_valid) begin
         check(dlv_cpu == e_cpu, e_tag, int'(dlv_cpu), int'(e_cpu));
         check($countones(dlv_cpu) == 1, "R1", int'(dlv_cpu), 1);
         check(dlv_irq == e_irq, "R10", int'(dlv_irq), int'(e_irq));
      end
      cfg_we = 1'b0; req_valid = 1'b0;
   endtask

   task automatic wr_hint(input int cpu, input logic [1:0] lvl);
      step(1'b1, 1'b1, cpu, 8'h00, 1'b0, lvl, 1'b0, 0, "R10");
   endtask

   task automatic wr_ent(input int irq, input logic [7:0] mask, input bit redir);
      step(1'b1, 1'b0, irq, mask, redir, 2'b00, 1'b0, 0, "R10");
   endtask

   task automatic req(input int irq, input string tag);
      step(1'b0, 1'b0, 0, 8'h00, 1'b0, 2'b00, 1'b1, irq, tag);
   endtask

   task automatic all_hints(input logic [1:0] lvl);
      for (int c = 0; c < NC; c++) wr_hint(c, lvl);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      int op, a;
      logic [7:0] mk;
      for (int i = 0; i < NI; i++) begin m_mask[i] = 8'h01; m_redir[i] = 1'b1; end
      for (int c = 0; c < NC; c++) m_hint[c] = 2'b00;
      void'($urandom(32'd20517));

      repeat (3) @(negedge clk);
      check(dlv_valid == 1'b0, "R10", int'(dlv_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset routing, both variants
      for (int i = 0; i < 16; i++) begin
         req(i, "R7");
         check(rr_valid && rr_cpu == 8'(1 << (i % NC)), "R8", int'(rr_cpu), 1 << (i % NC));
      end
      all_hints(2'b01);
      req(20, "R7");

      // Multi-bit mask, fixed mode ignores hints
      wr_ent(3, 8'b0110_1000, 1'b0);
      req(3, "R2");
      wr_hint(3, 2'b10);
      req(3, "R3");
      wr_hint(3, 2'b01);

      // Rotating search with ties
      wr_ent(7, 8'h20, 1'b1);
      req(7, "R4");
      wr_hint(2, 2'b00);
      req(7, "R4");
      wr_hint(6, 2'b00);
      req(7, "R4");
      wr_hint(2, 2'b01); wr_hint(6, 2'b01);

      // Offline CPUs skipped, all offline falls back to home
      wr_hint(5, 2'b10);
      req(7, "R6");
      all_hints(2'b10);
      req(7, "R6");
      wr_hint(4, 2'b01);
      req(7, "R6");
      wr_hint(4, 2'b10);

      // Code 2'b11 saturates: home still wins the all-offline tie
      wr_hint(5, 2'b11);
      req(7, "R5");
      check(dlv_cpu == 8'h20, "R5", int'(dlv_cpu), 8'h20);

      // Masked entry
      wr_ent(11, 8'h00, 1'b1);
      req(11, "R9");
      wr_ent(12, 8'h00, 1'b0);
      req(12, "R9");

      // Idle cycle after request
      req(7, "R10");
      step(1'b0, 1'b0, 0, 8'h00, 1'b0, 2'b00, 1'b0, 7, "R10");

      // Write and request to the same entry in one clock
      step(1'b1, 1'b0, 7, 8'h02, 1'b0, 2'b00, 1'b1, 7, "R11");
      check(dlv_cpu == 8'h20, "R11", int'(dlv_cpu), 8'h20);
      req(7, "R11");

      // Mode flag ignored without redirection
      all_hints(2'b00);
      wr_hint(4, 2'b10);
      wr_ent(9, 8'h10, 1'b1);
      req(9, "R8");
      check(rr_valid && rr_cpu == 8'h10, "R8", int'(rr_cpu), 8'h10);

      // Constrained random mix
      for (int it = 0; it < 600; it++) begin
         op = int'($urandom_range(0, 9));
         a  = int'($urandom_range(0, NI - 1));
         if (op < 3) begin
            step(1'b1, 1'b1, int'($urandom_range(0, NC - 1)), 8'h00, 1'b0,
                 2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
                 int'($urandom_range(0, 15)), "R4");
         end else if (op < 5) begin
            case ($urandom_range(0, 7))
               0:       mk = 8'h00;
               1, 2, 3: mk = 8'(1 << $urandom_range(0, NC - 1));
               default: mk = 8'($urandom);
            endcase
            step(1'b1, 1'b0, int'($urandom_range(0, 15)), mk, $urandom_range(0, 1) == 1,
                 2'b00, 1'b1, int'($urandom_range(0, 15)), "R11");
         end else begin
            a = a % 16;
            req(a, (m_mask[a] == '0) ? "R9" : (m_redir[a] ? "R4" : "R3"));
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule